// File: doc/BRIEF.md
# Phased Serial Word Deframer

This block turns a stream of serial bits into parallel video or control words. Each word is 20 bits long, sent least significant bit first at one bit per fast clock. A strobe marks the first bit of every word. A phase input, sampled with that strobe, says whether the word carries video or control content.

A video word holds two overhead flags and eighteen symbol bits. A control word holds one overhead flag and nine control bits. Five of the control bits are each sent three times and recovered by a two-of-three vote. The other four are sent once. The overhead flags describe a simple inversion scheme that keeps the line DC balanced, and the block undoes it before presenting the data.

Each completed word updates exactly one of the two registered output buses. A data-enable flag tells the downstream logic which bus was written last. The bus that was not written keeps its previous contents.

Top module: `serial_word_deframer`

## Requirements
- R1: While the synchronous active-high reset is applied, and after its release until the first complete word, the video bus, the control bus and the data-enable flag are all zero.
- R2: The bit presented together with the strobe is word position 0, and the bit on the k-th following clock is position k. Video symbol Sn is taken from position n+2.
- R3: In a video word, position 0 is the flag INV and position 1 is the flag ALT. The decoded symbol bit n is equal to the raw symbol bit, XORed with INV, and also XORed with ALT when n is odd.
- R4: In a control word, control bit Cm for m = 0..4 is the majority of positions 3m+1, 3m+2 and 3m+3, taken after the inversion of R6. A single flipped copy is corrected. Two flipped copies flip the result.
- R5: Control bits C5..C8 come straight from positions 16..19, after the inversion of R6, with no voting.
- R6: In a control word, position 0 is the flag INV. When it is 1, every other position is inverted before it is decoded.
- R7: A video word (phase input 1 at the strobe) drives data-enable to 1. A control word (phase input 0 at the strobe) drives it to 0.
- R8: A video word leaves the control bus unchanged, and a control word leaves the video bus unchanged.
- R9: The outputs change only on the clock edge that immediately follows the capture of position 19. Bits that arrive after a word is complete, with no new strobe, have no effect.
- R10: A strobe in the middle of a word drops the partial word and starts a new one. The phase is sampled only at the strobe, so changes to the phase input later in the word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit, one per clock |
| word_start | input | 1 | High on the clock that carries bit 0 of a word |
| phase_video | input | 1 | Sampled with word_start: 1 means video word, 0 means control word |
| video_out | output | 18 | Registered decoded video bus |
| ctrl_out | output | 9 | Registered decoded control bus |
| data_en | output | 1 | 1 after a video word, 0 after a control word |

## Verification
The cases that are hard to reach from the ports are the ones inside a single word. One is a triple holding one corrupted copy, or two, while the payload inversion flag is set. Another is a word that is cut short by a new strobe, or whose phase input changes after the strobe. The stimulus builds each word from the intended field values. It then applies an explicit bit-error mask, or sends only the first few bits, or flips the phase input from the second bit onward. Long runs of random back-to-back words with mixed phases then check the hold and update timing at every clock, using a behavioural model built on queues.

// File: rtl/deframe_pkg.sv
package deframe_pkg;

    localparam int VID_W    = 18;
    localparam int VID_OVH  = 2;
    localparam int CTL_OVH  = 1;
    localparam int VOTED_W  = 5;
    localparam int PLAIN_W  = 4;
    localparam int REP_N    = 3;
    localparam int CTL_W    = VOTED_W + PLAIN_W;
    localparam int WORD_W   = VID_OVH + VID_W;
    localparam int CWORD_W  = CTL_OVH + REP_N * VOTED_W + PLAIN_W;

    typedef enum logic {
        PH_CTRL  = 1'b0,
        PH_VIDEO = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [WORD_W-1:0]   bits;
    } word_s;

    typedef struct packed {
        logic [VID_W-1:0]    video;
        logic [CTL_W-1:0]    ctrl;
        logic                de;
    } out_s;

    // Majority of REP_N copies: true when more than half are set.
    function automatic logic vote(input logic [REP_N-1:0] copies);
        int ones;
        ones = 0;
        for (int i = 0; i < REP_N; i++) begin
            ones += int'(copies[i]);
        end
        return (ones > REP_N / 2);
    endfunction

endpackage

// File: rtl/word_collector.sv
module word_collector
    import deframe_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_bit,
    input  logic          word_start,
    input  logic          phase_in,
    output logic [WW-1:0] word_bits,
    output phase_e        word_phase,
    output logic          word_ready
);

    localparam int CNT_W = $clog2(WW + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WW - 1);

    // 0 means idle or finished; otherwise the next position to fill.
    logic [CNT_W-1:0] fill_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_pos   <= '0;
            word_bits  <= '0;
            word_phase <= PH_CTRL;
            word_ready <= 1'b0;
        end else begin
            word_ready <= 1'b0;
            if (word_start) begin
                word_bits[0] <= ser_bit;
                word_phase   <= phase_e'(phase_in);
                fill_pos     <= CNT_W'(1);
            end else if (fill_pos != '0) begin
                word_bits[fill_pos] <= ser_bit;
                if (fill_pos == LAST_POS) begin
                    fill_pos   <= '0;
                    word_ready <= 1'b1;
                end else begin
                    fill_pos <= fill_pos + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/video_decoder.sv
module video_decoder
    import deframe_pkg::*;
#(
    parameter int VW = VID_W
) (
    input  logic [VW+1:0] raw,
    output logic [VW-1:0] video
);

    logic          flag_inv;
    logic          flag_alt;
    logic [VW-1:0] odd_mask;
    logic [VW-1:0] flip;

    assign flag_inv = raw[0];
    assign flag_alt = raw[1];

    for (genvar g = 0; g < VW; g++) begin : g_mask
        assign odd_mask[g] = (g % 2 == 1);
    end

    assign flip  = {VW{flag_inv}} ^ (flag_alt ? odd_mask : '0);
    assign video = raw[VW+1:2] ^ flip;

endmodule

// File: rtl/control_decoder.sv
module control_decoder
    import deframe_pkg::*;
#(
    parameter int NV = VOTED_W,
    parameter int NP = PLAIN_W
) (
    input  logic [CTL_OVH + REP_N*NV + NP - 1:0] raw,
    output logic [NV+NP-1:0]                     ctrl
);

    localparam int RW = CTL_OVH + REP_N * NV + NP;

    logic [RW-2:0] payload;

    assign payload = raw[RW-1:1] ^ {(RW-1){raw[0]}};

    for (genvar g = 0; g < NV; g++) begin : g_voted
        assign ctrl[g] = vote(payload[REP_N*g +: REP_N]);
    end

    for (genvar g = 0; g < NP; g++) begin : g_plain
        assign ctrl[NV+g] = payload[REP_N*NV + g];
    end

endmodule

// File: rtl/serial_word_deframer.sv
module serial_word_deframer
    import deframe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    input  logic             word_start,
    input  logic             phase_video,
    output logic [VID_W-1:0] video_out,
    output logic [CTL_W-1:0] ctrl_out,
    output logic             data_en
);

    logic [WORD_W-1:0] word_bits;
    phase_e            word_phase;
    logic              word_ready;
    logic [VID_W-1:0]  dec_video;
    logic [CTL_W-1:0]  dec_ctrl;
    out_s              out_q;

    word_collector #(.WW(WORD_W)) i_collect (
        .clk        (clk),
        .rst        (rst),
        .ser_bit    (ser_bit),
        .word_start (word_start),
        .phase_in   (phase_video),
        .word_bits  (word_bits),
        .word_phase (word_phase),
        .word_ready (word_ready)
    );

    video_decoder #(.VW(VID_W)) i_vdec (
        .raw   (word_bits[VID_W+VID_OVH-1:0]),
        .video (dec_video)
    );

    control_decoder #(.NV(VOTED_W), .NP(PLAIN_W)) i_cdec (
        .raw  (word_bits[CWORD_W-1:0]),
        .ctrl (dec_ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (word_ready) begin
            if (word_phase == PH_VIDEO) begin
                out_q.video <= dec_video;
                out_q.de    <= 1'b1;
            end else begin
                out_q.ctrl  <= dec_ctrl;
                out_q.de    <= 1'b0;
            end
        end
    end

    assign video_out = out_q.video;
    assign ctrl_out  = out_q.ctrl;
    assign data_en   = out_q.de;

endmodule

// File: rtl/deframer_checker.sv
module deframer_checker
    import deframe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             word_start,
    input logic             phase_video,
    input logic [VID_W-1:0] video_out,
    input logic [CTL_W-1:0] ctrl_out,
    input logic             data_en
);

    localparam int CW = $clog2(WORD_W + 2);
    localparam logic [CW-1:0] DONE_AT = CW'(WORD_W);
    localparam logic [CW-1:0] SPENT   = CW'(WORD_W + 1);

    logic [CW-1:0] seen;
    logic          seen_phase;

    // Independent count of clocks since the last strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen       <= '0;
            seen_phase <= 1'b0;
        end else if (word_start) begin
            seen       <= CW'(1);
            seen_phase <= phase_video;
        end else if (seen != '0 && seen != SPENT) begin
            seen <= seen + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (video_out == '0 && ctrl_out == '0 && !data_en));

    assert_de_follows_phase_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(seen) == DONE_AT) |-> (data_en == $past(seen_phase)));

    assert_video_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(video_out) |-> data_en);

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_out) |-> !data_en);

    assert_update_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(video_out) || !$stable(ctrl_out) || !$stable(data_en))
        |-> ($past(seen) == DONE_AT));

endmodule

bind serial_word_deframer deframer_checker i_deframer_checker (
    .clk         (clk),
    .rst         (rst),
    .word_start  (word_start),
    .phase_video (phase_video),
    .video_out   (video_out),
    .ctrl_out    (ctrl_out),
    .data_en     (data_en)
);

// File: tb/test_serial_word_deframer.sv
module test_serial_word_deframer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_bit = 1'b0;
    logic        word_start = 1'b0;
    logic        phase_video = 1'b0;
    logic [17:0] video_out;
    logic [8:0]  ctrl_out;
    logic        data_en;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    serial_word_deframer i_serial_word_deframer (
        .clk         (clk),
        .rst         (rst),
        .ser_bit     (ser_bit),
        .word_start  (word_start),
        .phase_video (phase_video),
        .video_out   (video_out),
        .ctrl_out    (ctrl_out),
        .data_en     (data_en)
    );

    // ---------------- behavioural reference model ----------------
    bit          acc[$];
    bit          held[$];
    bit          acc_phase;
    bit          held_phase;
    bit          pending = 0;
    logic [17:0] exp_v = '0;
    logic [8:0]  exp_c = '0;
    logic        exp_de = 1'b0;

    task automatic apply_word();
        if (held_phase) begin
            for (int n = 0; n < 18; n++)
                exp_v[n] = held[n+2] ^ held[0] ^ (held[1] & (n % 2 == 1));
            exp_de = 1'b1;
        end else begin
            for (int m = 0; m < 5; m++) begin
                int ones = 0;
                for (int k = 1; k <= 3; k++) ones += int'(held[3*m+k] ^ held[0]);
                exp_c[m] = (ones >= 2);
            end
            for (int m = 5; m < 9; m++) exp_c[m] = held[m+11] ^ held[0];
            exp_de = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            acc.delete(); pending = 0;
            exp_v = '0; exp_c = '0; exp_de = 1'b0;
        end else begin
            if (pending) begin
                apply_word();
                pending = 0;
            end
            if (word_start) begin
                acc.delete();
                acc.push_back(ser_bit);
                acc_phase = phase_video;
            end else if (acc.size() > 0) begin
                acc.push_back(ser_bit);
                if (acc.size() == 20) begin
                    held = acc;
                    held_phase = acc_phase;
                    pending = 1;
                    acc.delete();
                end
            end
        end
        #1;
        if (!rst && !done) begin
            vectors++;
            if (video_out !== exp_v || ctrl_out !== exp_c || data_en !== exp_de) begin
                fails++;
                $display("FAIL %s: got v=%h c=%h de=%b, expected v=%h c=%h de=%b",
                         cur_req, video_out, ctrl_out, data_en, exp_v, exp_c, exp_de);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h, expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] vid_word(input logic [17:0] s, input logic inv, input logic alt);
        logic [17:0] p;
        p = s ^ {18{inv}} ^ (alt ? 18'h2AAAA : 18'h0);
        return {p, alt, inv};
    endfunction

    function automatic logic [19:0] ctl_word(input logic [8:0] c, input logic inv, input logic [19:0] err);
        logic [19:0] w;
        w = '0;
        for (int m = 0; m < 5; m++)
            for (int k = 1; k <= 3; k++) w[3*m+k] = c[m] ^ inv;
        for (int m = 5; m < 9; m++) w[m+11] = c[m] ^ inv;
        w[0] = inv;
        return w ^ err;
    endfunction

    task automatic send(input logic [19:0] w, input logic ph, input int nbits, input bit toggle);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            ser_bit     = w[k];
            word_start  = (k == 0);
            phase_video = (k == 0) ? ph : (toggle ? ~ph : ph);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            word_start = 1'b0;
            ser_bit    = $urandom_range(1);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R9: watchdog expired, got running, expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        check("R1", {video_out, ctrl_out, data_en}, 32'h0);
        rst = 1'b0;
        idle(2);
        check("R1", {video_out, ctrl_out, data_en}, 32'h0);

        cur_req = "R3";
        send(vid_word(18'h2A5C3, 0, 0), 1, 20, 0);
        idle(1);
        check("R9", video_out, 18'h0);              // not yet updated
        idle(1);
        check("R3", video_out, 18'h2A5C3);
        check("R7", data_en, 1'b1);
        send(vid_word(18'h12345, 1, 0), 1, 20, 0); idle(2);
        check("R3", video_out, 18'h12345);
        send(vid_word(18'h0F0F0, 0, 1), 1, 20, 0); idle(2);
        check("R3", video_out, 18'h0F0F0);
        send(vid_word(18'h3C3C3, 1, 1), 1, 20, 0); idle(2);
        check("R3", video_out, 18'h3C3C3);

        cur_req = "R2";
        send(20'h00004, 1, 20, 0); idle(2);
        check("R2", video_out, 18'h00001);
        send(20'h80000, 1, 20, 0); idle(2);
        check("R2", video_out, 18'h20000);
        send(vid_word(18'h3C3C3, 1, 1), 1, 20, 0); idle(2);

        cur_req = "R4";
        send(ctl_word(9'h1B5, 0, 20'h0), 0, 20, 0); idle(2);
        check("R4", ctrl_out, 9'h1B5);
        check("R7", data_en, 1'b0);
        check("R8", video_out, 18'h3C3C3);
        send(ctl_word(9'h04A, 1, 20'h08A14), 0, 20, 0); idle(2);
        check("R4", ctrl_out, 9'h04A);
        send(ctl_word(9'h000, 0, 20'h00006), 0, 20, 0); idle(2);
        check("R4", ctrl_out, 9'h001);              // two flipped copies
        cur_req = "R6";
        send(ctl_word(9'h0F3, 1, 20'h0), 0, 20, 0); idle(2);
        check("R6", ctrl_out, 9'h0F3);
        cur_req = "R5";
        send(ctl_word(9'h1E0, 0, 20'h0), 0, 20, 0); idle(2);
        check("R5", ctrl_out, 9'h1E0);
        send(ctl_word(9'h000, 0, 20'h20000), 0, 20, 0); idle(2);
        check("R5", ctrl_out, 9'h040);              // single bit, no vote

        cur_req = "R8";
        send(vid_word(18'h15555, 0, 0), 1, 20, 0); idle(2);
        check("R8", ctrl_out, 9'h040);
        check("R8", video_out, 18'h15555);

        cur_req = "R10";
        send(vid_word(18'h3FFFF, 0, 0), 1, 7, 0);
        send(ctl_word(9'h0AA, 0, 20'h0), 0, 20, 0); idle(2);
        check("R10", ctrl_out, 9'h0AA);
        check("R10", video_out, 18'h15555);
        send(vid_word(18'h0BEEF, 0, 0), 1, 20, 1); idle(2);
        check("R10", video_out, 18'h0BEEF);
        check("R10", data_en, 1'b1);

        cur_req = "R9";
        idle(40);
        check("R9", {video_out, ctrl_out, data_en}, {18'h0BEEF, 9'h0AA, 1'b1});

        cur_req = "R7";
        for (int i = 0; i < 300; i++) begin
            logic [19:0] w;
            w = $urandom();
            send(w, $urandom_range(1), 20, 0);
            if (i % 17 == 0) idle($urandom_range(3));
        end
        idle(3);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule